// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block sits behind a simple word-wide bus and behaves like the command layer of a parallel NOR flash. The array is a small on-chip memory. A bus write in the command state is taken as a command byte, and the writes that follow carry the data for that command. Four operations are supported: program one word, erase a sector, write a buffered block, and clear the status errors. Every operation completes at once, with no program or erase timing. The host reads back a status byte that holds a ready flag and two sticky error flags.

A write-protect input blocks every change to the array. While it is high, an erase or program command still goes through its full bus sequence and still ends with the ready flag set. The array stays as it was, and the erase-error or program-error flag is set. Reads have no side effects. A read returns either the addressed array word or the status byte, depending on the current read view.

Top module: `pflash_cmd_engine`

## Requirements
- R1: After reset, every array word reads 0xFF and the read view is the array. The status byte is 0x80, which means ready with no errors.
- R2: Reads return the status byte, zero-extended, from the moment a program, erase, buffered-write or clear-status command is accepted. They keep returning it until command 0xFF is accepted in the command state, which switches reads back to the array.
- R3: Command 0x10 or 0x40 makes the next bus write a program cycle. That write stores (old word AND data) at its address, even when the data is 0xFF. The block then returns to the command state and sets ready.
- R4: Command 0x20 followed by 0xD0 sets every word of the SECTOR_WORDS-aligned sector that holds the confirm address to 0xFF. No other word changes, and ready is set.
- R5: Command 0x20 followed by any byte other than 0xD0 leaves the array unchanged. It sets status bit 4 (program error) and bit 5 (erase error), and it sets ready.
- R6: Command 0xE8 starts a buffered write. The next write carries N-1 in its low log2(BLOCK_WORDS) bits. The N writes after that each buffer a word at the lane given by the low address bits. On the Nth write, the block ANDs every buffered lane into the BLOCK_WORDS-aligned block that holds that write's address, then sets ready.
- R7: With write protect high, a confirmed erase leaves the array unchanged, sets status bit 5 and sets ready.
- R8: With write protect high, a single program or a buffered write leaves the array unchanged, sets status bit 4 and sets ready.
- R9: Command 0x50 clears bits 4 and 5 and leaves ready unchanged. Otherwise the error bits stay set, including across later successful operations.
- R10: Ready (bit 7) reads 0 from the moment a program, erase or buffered-write command is accepted until that operation completes.
- R11: In the command state, a byte other than 0x10, 0x20, 0x40, 0x50, 0xE8 or 0xFF changes nothing: not the state, not the status, not the read view, not the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_protect | input | 1 | High blocks all array changes and reports errors instead |
| bus_we | input | 1 | Bus write strobe, one per cycle |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | DATA_W | Write data; low byte is the command code |
| bus_rdata | output | DATA_W | Array word or status byte, combinational from bus_addr |

## Verification
The assertions assume that each cycle with bus_we high is one complete bus write. They also assume that write protect does not change inside a command sequence, and that the count cycle of a buffered write is followed by that many data writes, all inside one block. The stimulus meets these assumptions. It issues writes through a task that holds the strobe for exactly one clock edge. It changes write protect only in the command state. It places each burst in a single aligned block. Every array word is swept after each class of operation and compared with a reference array that the bench builds from the requirements.

// File: rtl/pflash_pkg.sv
// Shared types and codes for the parallel flash command interpreter.
// Assumes 8-bit command codes carried in the low byte of a bus write.
package pflash_pkg;

    typedef enum logic [2:0] {
        ST_CMD,        // waiting for a command byte
        ST_PROG,       // next write is single-word program data
        ST_ERASE_CONF, // next write must be the erase confirm byte
        ST_BUF_CNT,    // next write carries the buffered word count
        ST_BUF_DATA    // collecting buffered data words
    } fsm_state_t;

    localparam int STAT_READY = 7;
    localparam int STAT_EERR  = 5;
    localparam int STAT_PERR  = 4;

    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_BUFWR    = 8'hE8;
    localparam logic [7:0] OP_CLRSTAT  = 8'h50;
    localparam logic [7:0] OP_READARR  = 8'hFF;

endpackage

// File: rtl/pflash_store.sv
// Flash array storage: one register per word, erased to all ones at reset.
// Supports a single-word AND-program, a whole-sector erase and a masked
// block commit, each completing in one cycle. Assumes at most one of the
// three enables is high in a cycle and that BLK_LG >= 1, SEC_LG < ADDR_W.
module pflash_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SEC_LG = 4,
    parameter int BLK_LG = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     prog_en,
    input  logic [ADDR_W-1:0]        prog_addr,
    input  logic [DATA_W-1:0]        prog_data,
    input  logic                     erase_en,
    input  logic [ADDR_W-1:0]        erase_addr,
    input  logic                     commit_en,
    input  logic [ADDR_W-1:0]        commit_addr,
    input  logic [(1<<BLK_LG)-1:0]   commit_mask,
    input  logic [(1<<BLK_LG)*DATA_W-1:0] commit_data
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int BLK   = 1 << BLK_LG;

    logic [DATA_W-1:0] words [WORDS];

    // Read port: plain combinational lookup.
    assign rd_data = words[rd_addr];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [ADDR_W-1:0] WA   = ADDR_W'(w);
        localparam int                LANE = w % BLK;

        logic              hit_sec;
        logic              hit_blk;
        logic              hit_prog;
        logic [DATA_W-1:0] word_q;

        assign hit_sec  = erase_en && (erase_addr[ADDR_W-1:SEC_LG] == WA[ADDR_W-1:SEC_LG]);
        assign hit_blk  = commit_en && commit_mask[LANE]
                          && (commit_addr[ADDR_W-1:BLK_LG] == WA[ADDR_W-1:BLK_LG]);
        assign hit_prog = prog_en && (prog_addr == WA);

        // Word update: erase wins, then block commit, then single program.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (hit_sec) begin
                word_q <= '1;
            end else if (hit_blk) begin
                word_q <= word_q & commit_data[LANE*DATA_W +: DATA_W];
            end else if (hit_prog) begin
                word_q <= word_q & prog_data;
            end
        end

        assign words[w] = word_q;
    end

endmodule

// File: rtl/pflash_wbuf.sv
// Write buffer for the buffered block write. Loads a remaining-word count,
// captures each data word into the lane given by the low address bits, and
// presents the buffered lanes (including the word of the current write) so
// the final write can be committed in the same cycle. Assumes load and wr are
// never high together.
module pflash_wbuf #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int BLK_LG = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [BLK_LG-1:0]        load_cnt,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     last,
    output logic [(1<<BLK_LG)-1:0]   commit_mask,
    output logic [(1<<BLK_LG)*DATA_W-1:0] commit_data
);
    localparam int BLK = 1 << BLK_LG;

    logic [BLK_LG-1:0]     cnt_q;
    logic [BLK-1:0]        valid_q;
    logic [BLK*DATA_W-1:0] buf_q;
    logic [BLK_LG-1:0]     lane;

    assign lane = wr_addr[BLK_LG-1:0];
    assign last = wr && (cnt_q == '0);

    // Count, valid lanes and buffered data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            valid_q <= '0;
            buf_q   <= '1;
        end else if (load) begin
            cnt_q   <= load_cnt;
            valid_q <= '0;
        end else if (wr) begin
            cnt_q                          <= cnt_q - 1'b1;
            valid_q[lane]                  <= 1'b1;
            buf_q[lane*DATA_W +: DATA_W]   <= wr_data;
        end
    end

    for (genvar l = 0; l < BLK; l++) begin : g_lane
        logic hit;
        assign hit = wr && (lane == BLK_LG'(l));
        assign commit_mask[l] = valid_q[l] | hit;
        assign commit_data[l*DATA_W +: DATA_W] = hit ? wr_data : buf_q[l*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/pflash_status.sv
// Status byte: ready flag plus sticky erase and program error flags.
// Reset gives ready with no errors. Assumes err_clr never coincides with an
// error set (the command decoder guarantees this).
module pflash_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready_clr,
    input  logic       ready_set,
    input  logic       perr_set,
    input  logic       eerr_set,
    input  logic       err_clr,
    output logic [7:0] status
);
    import pflash_pkg::*;

    logic ready_q;
    logic perr_q;
    logic eerr_q;

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
            perr_q  <= 1'b0;
            eerr_q  <= 1'b0;
        end else begin
            if (ready_set)      ready_q <= 1'b1;
            else if (ready_clr) ready_q <= 1'b0;
            if (err_clr) begin
                perr_q <= 1'b0;
                eerr_q <= 1'b0;
            end else begin
                if (perr_set) perr_q <= 1'b1;
                if (eerr_set) eerr_q <= 1'b1;
            end
        end
    end

    // Pack the flags into their byte positions.
    always_comb begin
        status             = '0;
        status[STAT_READY] = ready_q;
        status[STAT_EERR]  = eerr_q;
        status[STAT_PERR]  = perr_q;
    end

endmodule

// File: rtl/pflash_cmd_engine.sv
// Top of the parallel flash command interpreter. Decodes bus writes into
// program, erase, buffered write and status commands, drives the array,
// write buffer and status register, and selects array or status for reads.
// Assumes one bus write per cycle at most; all operations finish at once.
module pflash_cmd_engine #(
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 8,
    parameter int SECTOR_WORDS = 16,
    parameter int BLOCK_WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_protect,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    import pflash_pkg::*;

    localparam int SEC_LG = $clog2(SECTOR_WORDS);
    localparam int BLK_LG = $clog2(BLOCK_WORDS);
    localparam int BLK    = 1 << BLK_LG;

    fsm_state_t state_q, state_nxt;
    logic       show_status_q, show_status_nxt;
    logic [7:0] cmd;
    logic [7:0] status;
    logic [DATA_W-1:0] array_rd;

    logic prog_en, erase_en, commit_en;
    logic buf_load, buf_wr, buf_last;
    logic ready_clr, ready_set, perr_set, eerr_set, err_clr;
    logic [BLK-1:0]        commit_mask;
    logic [BLK*DATA_W-1:0] commit_data;

    assign cmd = bus_wdata[7:0];

    // Command decoder: next state, read view and one-cycle control strobes.
    always_comb begin
        state_nxt       = state_q;
        show_status_nxt = show_status_q;
        prog_en   = 1'b0;
        erase_en  = 1'b0;
        commit_en = 1'b0;
        buf_load  = 1'b0;
        buf_wr    = 1'b0;
        ready_clr = 1'b0;
        ready_set = 1'b0;
        perr_set  = 1'b0;
        eerr_set  = 1'b0;
        err_clr   = 1'b0;
        if (bus_we) begin
            unique case (state_q)
                ST_CMD: begin
                    unique case (cmd)
                        OP_PROG_A, OP_PROG_B: begin
                            state_nxt       = ST_PROG;
                            show_status_nxt = 1'b1;
                            ready_clr       = 1'b1;
                        end
                        OP_ERASE: begin
                            state_nxt       = ST_ERASE_CONF;
                            show_status_nxt = 1'b1;
                            ready_clr       = 1'b1;
                        end
                        OP_BUFWR: begin
                            state_nxt       = ST_BUF_CNT;
                            show_status_nxt = 1'b1;
                            ready_clr       = 1'b1;
                        end
                        OP_CLRSTAT: begin
                            err_clr         = 1'b1;
                            show_status_nxt = 1'b1;
                        end
                        OP_READARR: begin
                            show_status_nxt = 1'b0;
                        end
                        default: ;
                    endcase
                end
                ST_PROG: begin
                    prog_en   = !wr_protect;
                    perr_set  = wr_protect;
                    ready_set = 1'b1;
                    state_nxt = ST_CMD;
                end
                ST_ERASE_CONF: begin
                    if (cmd == OP_CONFIRM) begin
                        erase_en = !wr_protect;
                        eerr_set = wr_protect;
                    end else begin
                        perr_set = 1'b1;
                        eerr_set = 1'b1;
                    end
                    ready_set = 1'b1;
                    state_nxt = ST_CMD;
                end
                ST_BUF_CNT: begin
                    buf_load  = 1'b1;
                    state_nxt = ST_BUF_DATA;
                end
                ST_BUF_DATA: begin
                    buf_wr = 1'b1;
                    if (buf_last) begin
                        commit_en = !wr_protect;
                        perr_set  = wr_protect;
                        ready_set = 1'b1;
                        state_nxt = ST_CMD;
                    end
                end
                default: state_nxt = ST_CMD;
            endcase
        end
    end

    // State and read-view registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_CMD;
            show_status_q <= 1'b0;
        end else begin
            state_q       <= state_nxt;
            show_status_q <= show_status_nxt;
        end
    end

    pflash_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEC_LG (SEC_LG),
        .BLK_LG (BLK_LG)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_addr     (bus_addr),
        .rd_data     (array_rd),
        .prog_en     (prog_en),
        .prog_addr   (bus_addr),
        .prog_data   (bus_wdata),
        .erase_en    (erase_en),
        .erase_addr  (bus_addr),
        .commit_en   (commit_en),
        .commit_addr (bus_addr),
        .commit_mask (commit_mask),
        .commit_data (commit_data)
    );

    pflash_wbuf #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BLK_LG (BLK_LG)
    ) wbuf_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (buf_load),
        .load_cnt    (bus_wdata[BLK_LG-1:0]),
        .wr          (buf_wr),
        .wr_addr     (bus_addr),
        .wr_data     (bus_wdata),
        .last        (buf_last),
        .commit_mask (commit_mask),
        .commit_data (commit_data)
    );

    pflash_status status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_clr (ready_clr),
        .ready_set (ready_set),
        .perr_set  (perr_set),
        .eerr_set  (eerr_set),
        .err_clr   (err_clr),
        .status    (status)
    );

    // Read mux: status view or array word.
    assign bus_rdata = show_status_q ? DATA_W'(status) : array_rd;

endmodule

// File: rtl/pflash_cmd_chk.sv
// Checker for the parallel flash command interpreter: relates the decoder
// state, bus writes and the status register across cycles.
module pflash_cmd_chk #(
    parameter int DATA_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_protect,
    input logic                   bus_we,
    input logic [7:0]             cmd,
    input pflash_pkg::fsm_state_t state,
    input logic [7:0]             status,
    input logic                   show_status,
    input logic [DATA_W-1:0]      bus_rdata
);
    import pflash_pkg::*;

    logic in_cmd_we;
    logic known_cmd;
    assign in_cmd_we = bus_we && (state == ST_CMD);
    assign known_cmd = (cmd == OP_PROG_A) || (cmd == OP_PROG_B) || (cmd == OP_ERASE)
                    || (cmd == OP_BUFWR) || (cmd == OP_CLRSTAT) || (cmd == OP_READARR);

    // R10
    seq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CMD) |-> !status[STAT_READY]);

    // R8
    wp_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && bus_we && wr_protect) |=> (status[STAT_PERR] && status[STAT_READY]));

    // R7
    wp_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE_CONF && bus_we && wr_protect && cmd == OP_CONFIRM)
        |=> (status[STAT_EERR] && status[STAT_READY]));

    // R5
    bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE_CONF && bus_we && cmd != OP_CONFIRM)
        |=> (status[STAT_EERR] && status[STAT_PERR]));

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd_we && cmd == OP_CLRSTAT)
        |=> (!status[STAT_EERR] && !status[STAT_PERR] && $stable(status[STAT_READY])));

    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_PERR] && !(in_cmd_we && cmd == OP_CLRSTAT)) |=> status[STAT_PERR]);

    // R9
    eerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_EERR] && !(in_cmd_we && cmd == OP_CLRSTAT)) |=> status[STAT_EERR]);

    // R2
    status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        show_status |-> (bus_rdata == DATA_W'(status)));

    // R11
    unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd_we && !known_cmd)
        |=> ($stable(status) && $stable(show_status) && state == ST_CMD));

endmodule

bind pflash_cmd_engine pflash_cmd_chk #(
    .DATA_W (DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_protect  (wr_protect),
    .bus_we      (bus_we),
    .cmd         (cmd),
    .state       (state_q),
    .status      (status),
    .show_status (show_status_q),
    .bus_rdata   (bus_rdata)
);

// File: tb/pflash_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module pflash_cmd_engine_tb_top;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int WORDS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_protect = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] model [WORDS];

    always #4 clk = ~clk;

    pflash_cmd_engine #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .SECTOR_WORDS (16),
        .BLOCK_WORDS  (4)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_protect (wr_protect),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input int d);
        @(negedge clk);
        bus_addr  = ADDR_W'(a);
        bus_wdata = DATA_W'(d);
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
        bus_addr = ADDR_W'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    // Switch to array view and compare every word with the model.
    task automatic sweep(input string tag);
        bus_wr(0, 8'hFF);
        for (int a = 0; a < WORDS; a++) rd_chk(a, model[a], tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < WORDS; a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: erased array, array view, then status ready with no errors
        for (int a = 0; a < WORDS; a++) rd_chk(a, 8'hFF, "R1 reset array");
        bus_wr(0, 8'h50);
        rd_chk(0, 8'h80, "R1 reset status");

        // R3/R10: program every word, alternating both program codes
        for (int a = 0; a < WORDS; a++) begin
            logic [7:0] pat;
            pat = 8'((a * 37 + 5) & 255);
            bus_wr(a, (a % 2 == 1) ? 8'h10 : 8'h40);
            rd_chk(a, 8'h00, "R10 busy during program");
            bus_wr(a, pat);
            model[a] = model[a] & pat;
            rd_chk(a, 8'h80, "R3 ready after program");
        end
        sweep("R3 program sweep");
        // R3: second program ANDs; 0xFF as data is data, not a command
        bus_wr(3, 8'h40);
        bus_wr(3, 8'h0F);
        model[3] = model[3] & 8'h0F;
        bus_wr(9, 8'h10);
        bus_wr(9, 8'hFF);
        rd_chk(9, 8'h80, "R2 status view kept after program");
        sweep("R3 AND program");

        // R4: erase sector holding word 20 (words 16..31)
        bus_wr(20, 8'h20);
        rd_chk(20, 8'h00, "R10 busy during erase");
        bus_wr(20, 8'hD0);
        rd_chk(20, 8'h80, "R4 ready after erase");
        for (int a = 16; a < 32; a++) model[a] = 8'hFF;
        sweep("R4 erase sweep");

        // R5: bad confirm
        bus_wr(40, 8'h20);
        bus_wr(40, 8'h33);
        rd_chk(40, 8'hB0, "R5 bad confirm status");
        sweep("R5 array unchanged");
        bus_wr(0, 8'h50);
        rd_chk(0, 8'h80, "R9 clear after bad confirm");

        // R6: buffered writes of 1..4 words into the erased sector
        for (int n = 1; n <= 4; n++) begin
            int bb;
            bb = 16 + 4 * (n - 1);
            bus_wr(bb, 8'hE8);
            rd_chk(bb, 8'h00, "R10 busy at buffer start");
            bus_wr(bb, n - 1);
            for (int k = 0; k < n; k++) begin
                int wa;
                int wd;
                wa = bb + (3 - k);
                wd = (n * 16 + k * 3 + 1) & 255;
                bus_wr(wa, wd);
                model[wa] = model[wa] & 8'(wd);
                if (k < n - 1) rd_chk(wa, 8'h00, "R10 busy mid buffer");
            end
            rd_chk(bb, 8'h80, "R6 ready after buffer");
        end
        sweep("R6 buffered sweep");

        // R7/R8: write protect
        wr_protect = 1'b1;
        bus_wr(0, 8'h50);
        bus_wr(33, 8'h40);
        bus_wr(33, 8'h00);
        rd_chk(33, 8'h90, "R8 protected program");
        bus_wr(0, 8'h50);
        bus_wr(33, 8'h20);
        bus_wr(33, 8'hD0);
        rd_chk(33, 8'hA0, "R7 protected erase");
        bus_wr(0, 8'h50);
        bus_wr(0, 8'hE8);
        bus_wr(0, 1);
        bus_wr(0, 8'h00);
        bus_wr(1, 8'h00);
        rd_chk(0, 8'h90, "R8 protected buffer");
        wr_protect = 1'b0;
        sweep("R7 R8 array unchanged");

        // R9: errors stick across a successful program
        bus_wr(50, 8'h20);
        bus_wr(50, 8'h11);
        bus_wr(50, 8'h40);
        bus_wr(50, 8'hF0);
        model[50] = model[50] & 8'hF0;
        rd_chk(50, 8'hB0, "R9 sticky errors");
        bus_wr(0, 8'h50);
        rd_chk(0, 8'h80, "R9 cleared");

        // R11: unknown commands in array view and in status view
        bus_wr(0, 8'hFF);
        bus_wr(7, 8'h33);
        rd_chk(7, model[7], "R11 array view kept");
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h66);
        rd_chk(0, 8'h80, "R11 status kept");
        bus_wr(7, 8'h40);
        bus_wr(7, 8'h00);
        model[7] = 8'h00;
        rd_chk(7, 8'h80, "R11 still in command state");
        sweep("R11 final sweep");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule